// File: doc/BRIEF.md
# Auxiliary Channel Host Register Front-End

This block is the software-facing side of a display auxiliary-channel controller. A 32-bit register bus, addressed by byte with one register per 32-bit word, programs a target address, a control word and up to 16 bytes of outgoing data. Setting the request bit in the control word hands the request to a link-layer engine over a simple request/reply port. When the engine answers, or when a programmable cycle limit runs out first, the block captures the reply code, the returned byte count and the error flags into a status word. Received bytes are stored in a read-only buffer.

An interrupt unit collects four events: transfer finished, sink interrupt pulse, and the rising and falling edges of a synchronised hot-plug input. Each event has a sticky status bit and an enable bit. Software reads status, clears it by writing ones, and services the single interrupt line. The serial line coding and the pad control live outside the block.

Top module: `aux_host_regs`

## Requirements
- R1: Register word index equals byte address shifted right by two (address bits [1:0] ignored): 0 target address (20 bits), 1 control, 2 status, 3 interrupt enable, 4 interrupt status, 5 timeout limit, 8..11 transmit words, 12..15 receive words; other indices read 0, and writes to the receive words have no effect.
- R2: Byte k of a transfer sits in buffer word k/4 at bits 8*(k mod 4)+7 : 8*(k mod 4); the transmit words appear on eng_txdata and eng_rxdata fills the receive words with the same byte order.
- R3: Control bits [3:0] hold byte count minus one; eng_len carries that count plus one, except that control bit 8 (address-only) set with an I2C command gives eng_len 0; with a native command bit 8 is ignored.
- R4: Control bits [15:12] select the command: 0 I2C write, 1 I2C read, 2 I2C status-update request, 4/5/6 the same with middle-of-transaction set, 8 native write, 9 native read. A start request with any other code launches nothing.
- R5: Writing control with bit 16 set while idle raises eng_req for exactly the next cycle and bit 16 reads 1 until the transaction ends; control writes while busy are ignored.
- R6: A reply (eng_rsp while busy) ends the transaction and loads status bits [19:16] with the reply type (0 native ACK, 1 native NACK, 2 native DEFER, 4 I2C NACK, 8 I2C DEFER), bits [4:0] with the byte count, and the receive words; its error inputs set sticky flags at bit 9 (receive), 10 (sink), 11 (missing stop). eng_rsp while idle is ignored.
- R7: If no reply arrives, the transaction ends after exactly the timeout-limit number of busy cycles (reset value 64): status bit 8 is set, the receive words are unchanged, and interrupt status bit 0 (done) sets on the same edge as for a reply.
- R8: A status write clears each flag in bits [11:8] whose data bit is 1 (0xF00 clears all); a flag being set in the same cycle stays set.
- R9: Interrupt status bits are 0 done, 1 sink IRQ, 2 unplug, 3 plug, each cleared by writing 1; a new event in the clearing cycle wins; irq is high while any status bit is both set and enabled.
- R10: hpd_in passes two synchronising flops; status bit 28 reads the synchronised level; its rising edge sets interrupt bit 3 and its falling edge bit 2.
- R11: A one-cycle high on sink_irq sets interrupt status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Interrupt request |
| eng_req | output | 1 | One-cycle start pulse to the engine |
| eng_cmd | output | 4 | Command code of the request |
| eng_len | output | CNT_W | Bytes in the request, 0 for address-only |
| eng_addr | output | AUX_ADDR_W | Target address |
| eng_txdata | output | BUF_WORDS*32 | Transmit bytes, byte 0 in bits [7:0] |
| eng_rsp | input | 1 | Reply strobe |
| eng_rsp_type | input | 4 | Reply type code |
| eng_rsp_count | input | CNT_W | Bytes returned |
| eng_rsp_rxerr | input | 1 | Receive error |
| eng_rsp_sinkerr | input | 1 | Sink status error |
| eng_rsp_nostop | input | 1 | Missing stop error |
| eng_rxdata | input | BUF_WORDS*32 | Received bytes, byte 0 in bits [7:0] |
| hpd_in | input | 1 | Asynchronous hot-plug level |
| sink_irq | input | 1 | Sink interrupt pulse |

## Verification
Two collisions matter here: a reply that raises an error flag in the very cycle software writes the status word to clear flags, and a new interrupt event arriving in the cycle that the interrupt status is cleared by a write of ones. The bench drives both inputs on the same clock edge and then reads back, expecting the newly raised bit to survive while the other written bits are cleared. A behavioural model advanced on every edge is compared with the read data, the interrupt line and the start pulse on every cycle, which also pins down the exact cycle in which a timeout ends.

// File: rtl/aux_host_regs.sv
module aux_host_regs #(
  parameter int ADDR_W     = 6,
  parameter int AUX_ADDR_W = 20,
  parameter int TMO_W      = 16,
  parameter int TMO_DEF    = 64,
  parameter int BUF_WORDS  = 4,
  localparam int LEN_W     = $clog2(BUF_WORDS * 4),
  localparam int CNT_W     = LEN_W + 1,
  localparam int DW        = BUF_WORDS * 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  irq,
  output logic                  eng_req,
  output logic [3:0]            eng_cmd,
  output logic [CNT_W-1:0]      eng_len,
  output logic [AUX_ADDR_W-1:0] eng_addr,
  output logic [DW-1:0]         eng_txdata,
  input  logic                  eng_rsp,
  input  logic [3:0]            eng_rsp_type,
  input  logic [CNT_W-1:0]      eng_rsp_count,
  input  logic                  eng_rsp_rxerr,
  input  logic                  eng_rsp_sinkerr,
  input  logic                  eng_rsp_nostop,
  input  logic [DW-1:0]         eng_rxdata,
  input  logic                  hpd_in,
  input  logic                  sink_irq
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int I_ADDR = 0;
  localparam int I_CTRL = 1;
  localparam int I_STAT = 2;
  localparam int I_IEN  = 3;
  localparam int I_IST  = 4;
  localparam int I_TMO  = 5;
  localparam int I_TX   = 8;
  localparam int I_RX   = I_TX + BUF_WORDS;

  logic [IDX_W-1:0]      idx;
  logic [AUX_ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]      len_q;
  logic                  ao_q, busy_q, req_q;
  logic [3:0]            cmd_q;
  logic [TMO_W-1:0]      cnt_q, tmo_q;
  logic [DW-1:0]         tx_q, rx_q;
  logic [CNT_W-1:0]      rcnt_q;
  logic [3:0]            rtype_q, err_q, ien_q, ist_q;
  logic                  h1_q, h2_q, hd_q;
  logic                  wr_ctrl, wr_stat, wr_ist, start, fin_rsp, fin_tmo;
  logic [3:0]            err_set, err_clr, ev, ist_clr;
  logic                  cmd_ok;
  wire                   unused_lsb = &{1'b0, bus_addr[1:0]};

  assign idx     = bus_addr[ADDR_W-1:2];
  assign wr_ctrl = bus_wr && idx == IDX_W'(I_CTRL);
  assign wr_stat = bus_wr && idx == IDX_W'(I_STAT);
  assign wr_ist  = bus_wr && idx == IDX_W'(I_IST);

  always_comb begin
    case (bus_wdata[15:12])
      4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9: cmd_ok = 1'b1;
      default:                                         cmd_ok = 1'b0;
    endcase
  end

  assign start   = wr_ctrl && !busy_q && bus_wdata[16] && cmd_ok;
  assign fin_rsp = busy_q && eng_rsp;
  assign fin_tmo = busy_q && !eng_rsp && (cnt_q == tmo_q - TMO_W'(1));
  assign err_set = {fin_rsp & eng_rsp_nostop, fin_rsp & eng_rsp_sinkerr,
                    fin_rsp & eng_rsp_rxerr, fin_tmo};
  assign err_clr = wr_stat ? bus_wdata[11:8] : 4'd0;
  assign ev      = {h2_q & ~hd_q, ~h2_q & hd_q, sink_irq, fin_rsp | fin_tmo};
  assign ist_clr = wr_ist ? bus_wdata[3:0] : 4'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      len_q   <= '0;
      ao_q    <= 1'b0;
      cmd_q   <= '0;
      busy_q  <= 1'b0;
      req_q   <= 1'b0;
      cnt_q   <= '0;
      tmo_q   <= TMO_W'(TMO_DEF);
      tx_q    <= '0;
      rx_q    <= '0;
      rcnt_q  <= '0;
      rtype_q <= '0;
      err_q   <= '0;
      ien_q   <= '0;
      ist_q   <= '0;
      h1_q    <= 1'b0;
      h2_q    <= 1'b0;
      hd_q    <= 1'b0;
    end else begin
      req_q <= start;
      if (bus_wr && idx == IDX_W'(I_ADDR)) addr_q <= bus_wdata[AUX_ADDR_W-1:0];
      if (bus_wr && idx == IDX_W'(I_TMO))  tmo_q  <= bus_wdata[TMO_W-1:0];
      if (bus_wr && idx == IDX_W'(I_IEN))  ien_q  <= bus_wdata[3:0];
      if (wr_ctrl && !busy_q) begin
        len_q <= bus_wdata[LEN_W-1:0];
        ao_q  <= bus_wdata[8];
        cmd_q <= bus_wdata[15:12];
      end
      for (int w = 0; w < BUF_WORDS; w++)
        if (bus_wr && idx == IDX_W'(I_TX + w)) tx_q[w*32 +: 32] <= bus_wdata;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (fin_rsp || fin_tmo) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + TMO_W'(1);
      end
      if (fin_rsp) begin
        rx_q    <= eng_rxdata;
        rcnt_q  <= eng_rsp_count;
        rtype_q <= eng_rsp_type;
      end
      err_q <= (err_q & ~err_clr) | err_set;
      ist_q <= (ist_q & ~ist_clr) | ev;
      h1_q  <= hpd_in;
      h2_q  <= h1_q;
      hd_q  <= h2_q;
    end
  end

  assign eng_req    = req_q;
  assign eng_cmd    = cmd_q;
  assign eng_addr   = addr_q;
  assign eng_txdata = tx_q;
  assign eng_len    = (ao_q && !cmd_q[3]) ? '0 : CNT_W'(len_q) + CNT_W'(1);
  assign irq        = |(ist_q & ien_q);

  always_comb begin
    bus_rdata = '0;
    case (idx)
      IDX_W'(I_ADDR): bus_rdata[AUX_ADDR_W-1:0] = addr_q;
      IDX_W'(I_CTRL): begin
        bus_rdata[LEN_W-1:0] = len_q;
        bus_rdata[8]         = ao_q;
        bus_rdata[15:12]     = cmd_q;
        bus_rdata[16]        = busy_q;
      end
      IDX_W'(I_STAT): begin
        bus_rdata[CNT_W-1:0] = rcnt_q;
        bus_rdata[11:8]      = err_q;
        bus_rdata[19:16]     = rtype_q;
        bus_rdata[28]        = h2_q;
      end
      IDX_W'(I_IEN):  bus_rdata[3:0] = ien_q;
      IDX_W'(I_IST):  bus_rdata[3:0] = ist_q;
      IDX_W'(I_TMO):  bus_rdata[TMO_W-1:0] = tmo_q;
      default: ;
    endcase
    for (int w = 0; w < BUF_WORDS; w++) begin
      if (idx == IDX_W'(I_TX + w)) bus_rdata = tx_q[w*32 +: 32];
      if (idx == IDX_W'(I_RX + w)) bus_rdata = rx_q[w*32 +: 32];
    end
  end
endmodule

// File: rtl/aux_host_regs_chk.sv
module aux_host_regs_chk #(
  parameter int CNT_W = 5,
  parameter int RXW   = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             eng_req,
  input logic [CNT_W-1:0] eng_len,
  input logic [3:0]       eng_cmd,
  input logic             eng_rsp,
  input logic [RXW-1:0]   rx,
  input logic [3:0]       err,
  input logic [3:0]       ist,
  input logic [3:0]       ien,
  input logic             irq
);
  p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |=> !eng_req);

  p_req_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> busy);

  p_addr_only_i2c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_len == '0) |-> !eng_cmd[3]);

  p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && eng_rsp) |=> $stable(rx));

  p_done_on_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ist[0]);

  p_tmo_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err[0]) |-> $fell(busy));

  p_plug_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ist[3]) && ien[3]) |-> irq);
endmodule

bind aux_host_regs aux_host_regs_chk #(.CNT_W(CNT_W), .RXW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .eng_req(eng_req), .eng_len(eng_len),
  .eng_cmd(eng_cmd), .eng_rsp(eng_rsp), .rx(rx_q), .err(err_q), .ist(ist_q),
  .ien(ien_q), .irq(irq)
);

// File: tb/aux_host_regs_tb_top.sv
`timescale 1ns/1ps
module aux_host_regs_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [5:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         irq, eng_req;
  logic [3:0]   eng_cmd;
  logic [4:0]   eng_len;
  logic [19:0]  eng_addr;
  logic [127:0] eng_txdata;
  logic         eng_rsp = 1'b0;
  logic [3:0]   eng_rsp_type = '0;
  logic [4:0]   eng_rsp_count = '0;
  logic         eng_rsp_rxerr = 1'b0, eng_rsp_sinkerr = 1'b0, eng_rsp_nostop = 1'b0;
  logic [127:0] eng_rxdata = '0;
  logic         hpd_in = 1'b0, sink_irq = 1'b0;

  always #4 clk = ~clk;

  aux_host_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .eng_req(eng_req),
    .eng_cmd(eng_cmd), .eng_len(eng_len), .eng_addr(eng_addr),
    .eng_txdata(eng_txdata), .eng_rsp(eng_rsp), .eng_rsp_type(eng_rsp_type),
    .eng_rsp_count(eng_rsp_count), .eng_rsp_rxerr(eng_rsp_rxerr),
    .eng_rsp_sinkerr(eng_rsp_sinkerr), .eng_rsp_nostop(eng_rsp_nostop),
    .eng_rxdata(eng_rxdata), .hpd_in(hpd_in), .sink_irq(sink_irq)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic note(input bit ok, input string tag, input logic [127:0] act,
                      input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [19:0]  m_addr;
  logic [3:0]   m_len, m_cmd, m_rtype, m_err, m_ien, m_ist;
  logic         m_ao, m_busy, m_req, m_h1, m_h2, m_hd;
  int           m_cnt, m_tmo;
  logic [127:0] m_tx, m_rx;
  logic [4:0]   m_rcnt;

  function automatic bit legal(input logic [3:0] c);
    return c inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = '0; m_len = '0; m_cmd = '0; m_rtype = '0; m_err = '0;
      m_ien = '0; m_ist = '0; m_ao = 0; m_busy = 0; m_req = 0;
      m_h1 = 0; m_h2 = 0; m_hd = 0; m_cnt = 0; m_tmo = 64;
      m_tx = '0; m_rx = '0; m_rcnt = '0;
    end else begin
      automatic int ix = int'(bus_addr) >> 2;
      automatic bit st = bus_wr && ix == 1 && !m_busy && bus_wdata[16] && legal(bus_wdata[15:12]);
      automatic bit fr = m_busy && eng_rsp;
      automatic bit ft = m_busy && !eng_rsp && (m_cnt == m_tmo - 1);
      automatic logic [3:0] ev = {m_h2 & ~m_hd, ~m_h2 & m_hd, sink_irq, fr | ft};
      automatic logic [3:0] es = {fr & eng_rsp_nostop, fr & eng_rsp_sinkerr, fr & eng_rsp_rxerr, ft};
      m_err = (m_err & ~((bus_wr && ix == 2) ? bus_wdata[11:8] : 4'd0)) | es;
      m_ist = (m_ist & ~((bus_wr && ix == 4) ? bus_wdata[3:0] : 4'd0)) | ev;
      if (bus_wr) begin
        if (ix == 0) m_addr = bus_wdata[19:0];
        if (ix == 3) m_ien = bus_wdata[3:0];
        if (ix == 5) m_tmo = int'(bus_wdata[15:0]);
        if (ix >= 8 && ix < 12) m_tx[(ix-8)*32 +: 32] = bus_wdata;
        if (ix == 1 && !m_busy) begin
          m_len = bus_wdata[3:0]; m_ao = bus_wdata[8]; m_cmd = bus_wdata[15:12];
        end
      end
      if (fr) begin
        m_rx = eng_rxdata; m_rcnt = eng_rsp_count; m_rtype = eng_rsp_type;
      end
      m_req = st;
      if (st) begin m_busy = 1; m_cnt = 0; end
      else if (fr || ft) m_busy = 0;
      else if (m_busy) m_cnt++;
      m_hd = m_h2; m_h2 = m_h1; m_h1 = hpd_in;
    end
  end

  function automatic logic [31:0] exp_rd(input int ix);
    logic [31:0] r = '0;
    case (ix)
      0: r[19:0] = m_addr;
      1: begin r[3:0] = m_len; r[8] = m_ao; r[15:12] = m_cmd; r[16] = m_busy; end
      2: begin r[4:0] = m_rcnt; r[11:8] = m_err; r[19:16] = m_rtype; r[28] = m_h2; end
      3: r[3:0] = m_ien;
      4: r[3:0] = m_ist;
      5: r[15:0] = 16'(m_tmo);
      8, 9, 10, 11: r = m_tx[(ix-8)*32 +: 32];
      12, 13, 14, 15: r = m_rx[(ix-12)*32 +: 32];
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input int ix);
    case (ix)
      0, 6, 7: return "R1";
      1: return "R5";
      2: return "R6";
      3, 4: return "R9";
      5: return "R7";
      default: return "R2";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      automatic int ix = int'(bus_addr) >> 2;
      note(bus_rdata === exp_rd(ix), {tag_of(ix), " model rdata"}, bus_rdata, exp_rd(ix));
      note(irq === |(m_ist & m_ien), "R9 model irq", irq, |(m_ist & m_ien));
      note(eng_req === m_req, "R5 model eng_req", eng_req, m_req);
      if (m_req) begin
        note(eng_len === ((m_ao && !m_cmd[3]) ? 5'd0 : 5'(m_len) + 5'd1), "R3 model eng_len",
             eng_len, (m_ao && !m_cmd[3]) ? 5'd0 : 5'(m_len) + 5'd1);
        note(eng_cmd === m_cmd, "R4 model eng_cmd", eng_cmd, m_cmd);
        note(eng_addr === m_addr, "R1 model eng_addr", eng_addr, m_addr);
        note(eng_txdata === m_tx, "R2 model eng_txdata", eng_txdata, m_tx);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    note(bus_rdata === exp, tag, bus_rdata, exp);
    tick();
  endtask

  task automatic rsp(input logic [3:0] t, input logic [4:0] c, input logic e_rx,
                     input logic e_sink, input logic e_ns, input logic [127:0] d);
    eng_rsp = 1'b1; eng_rsp_type = t; eng_rsp_count = c; eng_rsp_rxerr = e_rx;
    eng_rsp_sinkerr = e_sink; eng_rsp_nostop = e_ns; eng_rxdata = d;
    tick();
    eng_rsp = 1'b0; eng_rsp_rxerr = 1'b0; eng_rsp_sinkerr = 1'b0; eng_rsp_nostop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    // reset state
    rd(6'h04, 32'h0, "R5 reset ctrl");
    rd(6'h08, 32'h0, "R6 reset status");
    rd(6'h14, 32'd64, "R7 reset timeout limit");
    rd(6'h10, 32'h0, "R9 reset int status");
    note(irq === 1'b0, "R9 reset irq", irq, 1'b0);
    // map
    wr(6'h00, 32'h0012345);
    rd(6'h00, 32'h12345, "R1 address readback");
    rd(6'h02, 32'h12345, "R1 low address bits ignored");
    rd(6'h18, 32'h0, "R1 unmapped index");
    // native write, 4 bytes
    wr(6'h20, 32'h44332211);
    wr(6'h24, 32'h88776655);
    wr(6'h28, 32'hCCBBAA99);
    wr(6'h2C, 32'h00FFEEDD);
    rd(6'h24, 32'h88776655, "R2 tx word readback");
    wr(6'h04, 32'h00018003);
    note(eng_req === 1'b1, "R5 start pulse", eng_req, 1'b1);
    note(eng_len === 5'd4, "R3 length plus one", eng_len, 5'd4);
    note(eng_cmd === 4'd8, "R4 native write code", eng_cmd, 4'd8);
    note(eng_txdata[7:0] === 8'h11, "R2 byte 0 position", eng_txdata[7:0], 8'h11);
    note(eng_txdata[39:32] === 8'h55, "R2 byte 4 position", eng_txdata[39:32], 8'h55);
    rd(6'h04, 32'h00018003, "R5 busy readback");
    wr(6'h04, 32'h00009005);
    rd(6'h04, 32'h00018003, "R5 ctrl write while busy ignored");
    rsp(4'd0, 5'd0, 0, 0, 0, 128'h0);
    rd(6'h04, 32'h00008003, "R6 busy clears on reply");
    rd(6'h10, 32'h1, "R7 done status");
    // native read, 16 bytes
    wr(6'h04, 32'h0001900F);
    note(eng_len === 5'd16, "R3 full length", eng_len, 5'd16);
    rsp(4'd0, 5'd16, 0, 0, 0, 128'h0F0E0D0C_0B0A0908_07060504_03020100);
    rd(6'h30, 32'h03020100, "R2 rx word 0");
    rd(6'h3C, 32'h0F0E0D0C, "R2 rx word 3");
    rd(6'h08, 32'h00000010, "R6 count captured");
    wr(6'h30, 32'hDEADBEEF);
    rd(6'h30, 32'h03020100, "R1 rx write ignored");
    // address-only I2C read with MOT
    wr(6'h04, 32'h00015107);
    note(eng_len === 5'd0, "R3 address-only I2C", eng_len, 5'd0);
    note(eng_cmd === 4'd5, "R4 I2C read MOT code", eng_cmd, 4'd5);
    rsp(4'd4, 5'd0, 0, 0, 0, 128'hBEEF);
    rd(6'h08, 32'h00040000, "R6 I2C NACK type");
    // address-only bit with native read is ignored
    wr(6'h04, 32'h00019101);
    note(eng_len === 5'd2, "R3 address-only ignored for native", eng_len, 5'd2);
    rsp(4'd2, 5'd2, 0, 0, 0, 128'hBEEF);
    rd(6'h08, 32'h00020002, "R6 native DEFER type");
    // reply while idle ignored
    rsp(4'd8, 5'd7, 1, 1, 1, 128'h1234);
    rd(6'h08, 32'h00020002, "R6 idle reply ignored");
    // unsupported command
    wr(6'h04, 32'h00013000);
    note(eng_req === 1'b0, "R4 unsupported code no start", eng_req, 1'b0);
    rd(6'h04, 32'h00003000, "R4 unsupported code stays idle");
    // timeout
    wr(6'h14, 32'd5);
    rd(6'h14, 32'd5, "R7 limit readback");
    wr(6'h04, 32'h00010000);
    for (int i = 0; i < 5; i++) rd(6'h04, 32'h00010000, "R7 busy within limit");
    rd(6'h04, 32'h00000000, "R7 ends at limit");
    rd(6'h08, 32'h00020102, "R7 timeout flag");
    rd(6'h30, 32'h0000BEEF, "R7 rx unchanged");
    // error flags and clearing
    wr(6'h04, 32'h00019000);
    rsp(4'd1, 5'd0, 1, 0, 1, 128'hBEEF);
    rd(6'h08, 32'h00010B00, "R6 error flags");
    wr(6'h08, 32'h00000200);
    rd(6'h08, 32'h00010900, "R8 selective clear");
    wr(6'h08, 32'h00000F00);
    rd(6'h08, 32'h00010000, "R8 clear all");
    wr(6'h04, 32'h00019000);
    rsp(4'd0, 5'd1, 0, 0, 1, 128'hBEEF);
    rd(6'h08, 32'h00000801, "R6 missing stop flag");
    wr(6'h04, 32'h00019000);
    bus_wr = 1'b1; bus_addr = 6'h08; bus_wdata = 32'hF00;
    eng_rsp = 1'b1; eng_rsp_type = 4'd0; eng_rsp_count = 5'd1; eng_rsp_sinkerr = 1'b1;
    tick();
    bus_wr = 1'b0; eng_rsp = 1'b0; eng_rsp_sinkerr = 1'b0;
    rd(6'h08, 32'h00000401, "R8 set wins over clear");
    // interrupts
    wr(6'h10, 32'hF);
    rd(6'h10, 32'h0, "R9 write one clears");
    wr(6'h0C, 32'hF);
    sink_irq = 1'b1; tick(); sink_irq = 1'b0;
    rd(6'h10, 32'h2, "R11 sink pulse");
    note(irq === 1'b1, "R9 irq when enabled", irq, 1'b1);
    wr(6'h10, 32'h2);
    rd(6'h10, 32'h0, "R11 sink status cleared");
    hpd_in = 1'b1; tick(); tick();
    rd(6'h08, 32'h10000401, "R10 synchronised level");
    rd(6'h10, 32'h8, "R10 plug on rise");
    hpd_in = 1'b0; tick(); tick(); tick();
    rd(6'h10, 32'hC, "R10 unplug on fall");
    bus_wr = 1'b1; bus_addr = 6'h10; bus_wdata = 32'hF; sink_irq = 1'b1;
    tick();
    bus_wr = 1'b0; sink_irq = 1'b0;
    rd(6'h10, 32'h2, "R9 event wins over clear");
    wr(6'h0C, 32'h1);
    rd(6'h10, 32'h2, "R9 masked status kept");
    note(irq === 1'b0, "R9 masked irq low", irq, 1'b0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule